// File: doc/BRIEF.md
# Storage Controller Register Front-End

This block turns accesses on a 4 KB memory-mapped bus window into accesses on the register port of an IDE-style drive. The bus side is a single-cycle port that gives an address, a direction, write data and a size code of 1, 2 or 4 bytes. The front-end takes a register index from bits 11:4 of the address and checks the access size against the rules for that register. A legal access becomes a one-cycle strobe toward the drive's data port, its task-file registers, its alternate status register or its device control register. Read data comes back in the same cycle.

Two registers live inside the block: a 32-bit timing register that software can read and write, and a 32-bit interrupt state register. The interrupt state register shows the DMA interrupt in bit 31 and the disk interrupt in bit 30. Software clears the DMA bit by writing a 1 to it. The disk bit only copies the disk line. Both interrupt inputs are also forwarded unchanged to two separate outputs.

Top module: `stor_reg_frontend`

## Requirements
- R1: The register index is `bus_addr[11:4]`. A read of any index other than 0x00–0x08, 0x16, 0x20 or 0x30 returns 0xFFFFFFFF and raises no strobe. The size code on `bus_size` is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. At most one strobe is active in any cycle.
- R2: Index 0 is the data port. Reads of 2 or 4 bytes pulse `dp_rd` and return the low 16 bits or all 32 bits of `dp_rdata`. `dp_wide` is 1 only for the 4-byte size. A 1-byte read returns `dp_rdata[7:0]`. Writes of 2 or 4 bytes pulse `dp_wr`. A 1-byte write raises no strobe.
- R3: Indices 1 to 7 take only 1-byte accesses. A read pulses `tf_rd` and a write pulses `tf_wr`, with `tf_sel` equal to the index. A read returns `tf_rdata` zero-extended. An access of any other size raises no strobe, and a read of that kind returns 0xFFFFFFFF.
- R4: Indices 0x08 and 0x16 take only 1-byte accesses. A read pulses `stat_rd` and returns `alt_stat` zero-extended. A write pulses `ctl_wr`. An access of any other size raises no strobe, and a read of that kind returns 0xFFFFFFFF.
- R5: Index 0x20 is the timing register. A 4-byte write loads it and a 4-byte read returns it. A write of any other size leaves it unchanged. A read of any other size returns 0xFFFFFFFF.
- R6: Index 0x30 is the interrupt state register and can be read only with 4 bytes. It returns the DMA bit in bit 31, the disk bit in bit 30 and zeros elsewhere. A read of any other size returns 0xFFFFFFFF.
- R7: The DMA bit sets on the clock edge that first sees `dma_irq_in` high and clears on the edge that first sees it low. A 4-byte write to index 0x30 with bit 31 set clears the DMA bit. If an input edge and such a write fall in the same cycle, the input edge wins. Other written bits have no effect.
- R8: The disk bit takes the value of `disk_irq_in` at each clock edge. A write cannot clear it.
- R9: `dma_irq_out` equals `dma_irq_in` and `disk_irq_out` equals `disk_irq_in`, without delay.
- R10: Reset clears the timing register and the interrupt state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address in the window |
| bus_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| dp_rd | output | 1 | Data port read strobe |
| dp_wr | output | 1 | Data port write strobe |
| dp_wide | output | 1 | Data port access is 32 bits |
| dp_wdata | output | 32 | Data port write data |
| dp_rdata | input | 32 | Data port read data |
| tf_rd | output | 1 | Task-file read strobe |
| tf_wr | output | 1 | Task-file write strobe |
| tf_sel | output | 3 | Task-file register select |
| tf_wdata | output | 8 | Task-file and control write data |
| tf_rdata | input | 8 | Task-file read data |
| stat_rd | output | 1 | Alternate status read strobe |
| alt_stat | input | 8 | Alternate status value |
| ctl_wr | output | 1 | Device control write strobe |
| dma_irq_in | input | 1 | DMA interrupt line |
| disk_irq_in | input | 1 | Disk interrupt line |
| dma_irq_out | output | 1 | Forwarded DMA interrupt |
| disk_irq_out | output | 1 | Forwarded disk interrupt |

## Verification
The DMA bit can be changed by two things in the same clock edge: a write-one-to-clear from software and an edge on the DMA input. The bench sets up this conflict by raising `dma_irq_in` on the same cycle as a 4-byte write of bit 31 to index 0x30. It then reads the register back and expects bit 31 to be set. A second case clears the bit with a write while the line does not change, and the bench expects the bit to read as zero.

// File: rtl/stor_reg_frontend.sv
module stor_reg_frontend (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [11:0] bus_addr,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        dp_rd,
  output logic        dp_wr,
  output logic        dp_wide,
  output logic [31:0] dp_wdata,
  input  logic [31:0] dp_rdata,
  output logic        tf_rd,
  output logic        tf_wr,
  output logic [2:0]  tf_sel,
  output logic [7:0]  tf_wdata,
  input  logic [7:0]  tf_rdata,
  output logic        stat_rd,
  input  logic [7:0]  alt_stat,
  output logic        ctl_wr,
  input  logic        dma_irq_in,
  input  logic        disk_irq_in,
  output logic        dma_irq_out,
  output logic        disk_irq_out
);

  localparam logic [7:0] IX_DATA = 8'h00;
  localparam logic [7:0] IX_STA0 = 8'h08;
  localparam logic [7:0] IX_STA1 = 8'h16;
  localparam logic [7:0] IX_TIME = 8'h20;
  localparam logic [7:0] IX_IRQS = 8'h30;

  logic [7:0] idx;
  logic       sz1, sz2, sz4, rd, wr;
  logic       hit_tf, hit_st, tim_we, irq_we;
  logic [31:0] timing_q;
  logic        st_dma, st_disk, dma_q;

  assign idx = bus_addr[11:4];
  assign sz1 = bus_size == 2'd0;
  assign sz2 = bus_size == 2'd1;
  assign sz4 = bus_size == 2'd2;
  assign rd  = bus_valid & ~bus_write;
  assign wr  = bus_valid & bus_write;

  assign hit_tf = (idx >= 8'd1) && (idx <= 8'd7);
  assign hit_st = (idx == IX_STA0) || (idx == IX_STA1);

  assign dp_rd    = rd & (idx == IX_DATA) & (sz1 | sz2 | sz4);
  assign dp_wr    = wr & (idx == IX_DATA) & (sz2 | sz4);
  assign dp_wide  = sz4;
  assign dp_wdata = bus_wdata;

  assign tf_rd    = rd & hit_tf & sz1;
  assign tf_wr    = wr & hit_tf & sz1;
  assign tf_sel   = idx[2:0];
  assign tf_wdata = bus_wdata[7:0];

  assign stat_rd  = rd & hit_st & sz1;
  assign ctl_wr   = wr & hit_st & sz1;

  assign tim_we   = wr & (idx == IX_TIME) & sz4;
  assign irq_we   = wr & (idx == IX_IRQS) & sz4;

  assign dma_irq_out  = dma_irq_in;
  assign disk_irq_out = disk_irq_in;

  always_comb begin
    bus_rdata = 32'hFFFF_FFFF;
    if (dp_rd)
      bus_rdata = sz4 ? dp_rdata : sz2 ? {16'h0, dp_rdata[15:0]} : {24'h0, dp_rdata[7:0]};
    else if (tf_rd)
      bus_rdata = {24'h0, tf_rdata};
    else if (stat_rd)
      bus_rdata = {24'h0, alt_stat};
    else if (rd && sz4 && idx == IX_TIME)
      bus_rdata = timing_q;
    else if (rd && sz4 && idx == IX_IRQS)
      bus_rdata = {st_dma, st_disk, 30'h0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timing_q <= '0;
      st_dma   <= 1'b0;
      st_disk  <= 1'b0;
      dma_q    <= 1'b0;
    end else begin
      dma_q   <= dma_irq_in;
      st_disk <= disk_irq_in;
      if (tim_we) timing_q <= bus_wdata;
      if (dma_irq_in && !dma_q)      st_dma <= 1'b1;
      else if (!dma_irq_in && dma_q) st_dma <= 1'b0;
      else if (irq_we && bus_wdata[31]) st_dma <= 1'b0;
    end
  end

  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dp_rd, dp_wr, tf_rd, tf_wr, stat_rd, ctl_wr, tim_we, irq_we}));

  a_r3_byte_only: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_rd || tf_wr || stat_rd || ctl_wr) |-> bus_size == 2'd0);

  a_r5_timing_load: assert property (@(posedge clk) disable iff (!rst_n)
    tim_we |=> timing_q == $past(bus_wdata));

  a_r7_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_irq_in && !dma_q) |=> st_dma);

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_we && bus_wdata[31] && dma_irq_in == dma_q) |=> !st_dma);

  a_r8_disk_copy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> st_disk == $past(disk_irq_in));

endmodule

// File: tb/stor_reg_frontend_bench.sv
module stor_reg_frontend_bench;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic dp_rd, dp_wr, dp_wide, tf_rd, tf_wr, stat_rd, ctl_wr;
  logic [31:0] dp_wdata, dp_rdata;
  logic [2:0] tf_sel;
  logic [7:0] tf_wdata, tf_rdata, alt_stat;
  logic dma_irq_in = 0, disk_irq_in = 0, dma_irq_out, disk_irq_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign dp_rdata = 32'hA1B2_C3D4;
  assign tf_rdata = 8'h50 | {5'b0, tf_sel};
  assign alt_stat = 8'h5A;

  stor_reg_frontend u_stor_reg_frontend (.*);

  typedef struct {
    bit chk_rd; logic [31:0] rdata; logic [5:0] strb;
    logic wide; logic [2:0] sel; string tag;
  } exp_t;
  exp_t q[$];

  task automatic acc(input bit w, input logic [11:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, input bit chk, input logic [31:0] er,
                     input logic [5:0] es, input string tag);
    exp_t e;
    @(negedge clk);
    bus_valid = 1; bus_write = w; bus_addr = a; bus_size = sz; bus_wdata = wd;
    e.chk_rd = chk; e.rdata = er; e.strb = es; e.wide = (sz == 2'd2);
    e.sel = a[6:4]; e.tag = tag;
    q.push_back(e);
    @(posedge clk); #1;
    bus_valid = 0;
  endtask

  always begin
    @(negedge clk); #1;
    if (q.size() > 0) begin
      exp_t e;
      logic [5:0] s;
      e = q.pop_front();
      s = {dp_rd, dp_wr, tf_rd, tf_wr, stat_rd, ctl_wr};
      n_chk++;
      if (s != e.strb || (e.chk_rd && bus_rdata != e.rdata) || dp_wide != e.wide || tf_sel != e.sel) begin
        n_fail++;
        $display("FAIL %s: rdata=%h strb=%b wide=%b sel=%0d expected rdata=%h strb=%b wide=%b sel=%0d",
                 e.tag, bus_rdata, s, dp_wide, tf_sel, e.rdata, e.strb, e.wide, e.sel);
      end
    end
  end

  task automatic chk_irq(input string tag);
    n_chk++;
    if (dma_irq_out !== dma_irq_in || disk_irq_out !== disk_irq_in) begin
      n_fail++;
      $display("FAIL %s: outs=%b%b expected %b%b", tag, dma_irq_out, disk_irq_out, dma_irq_in, disk_irq_in);
    end
  endtask

  task automatic set_irq(input logic d, input logic k);
    @(negedge clk); dma_irq_in = d; disk_irq_in = k;
    #1 chk_irq("R9 passthrough");
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    acc(0, 12'h200, 2, 0, 1, 32'h0, 6'b000000, "R10 timing after reset");
    acc(0, 12'h300, 2, 0, 1, 32'h0, 6'b000000, "R10 irq state after reset");
    // R5
    acc(1, 12'h200, 2, 32'hDEADBEEF, 0, 0, 6'b000000, "R5 timing write");
    acc(0, 12'h200, 2, 0, 1, 32'hDEADBEEF, 6'b000000, "R5 timing readback");
    acc(1, 12'h200, 0, 32'h11, 0, 0, 6'b000000, "R5 byte write ignored");
    acc(0, 12'h200, 2, 0, 1, 32'hDEADBEEF, 6'b000000, "R5 timing unchanged");
    acc(0, 12'h200, 1, 0, 1, 32'hFFFFFFFF, 6'b000000, "R5 wrong size read");
    // R2
    acc(0, 12'h000, 2, 0, 1, 32'hA1B2C3D4, 6'b100000, "R2 32-bit read");
    acc(0, 12'h004, 1, 0, 1, 32'h0000C3D4, 6'b100000, "R2 16-bit read");
    acc(0, 12'h000, 0, 0, 1, 32'h000000D4, 6'b100000, "R2 byte read");
    acc(1, 12'h000, 0, 32'h77, 0, 0, 6'b000000, "R2 byte write ignored");
    acc(1, 12'h000, 1, 32'h1234, 0, 0, 6'b010000, "R2 16-bit write");
    acc(1, 12'h008, 2, 32'h12345678, 0, 0, 6'b010000, "R2 32-bit write");
    // R3
    acc(0, 12'h030, 0, 0, 1, 32'h53, 6'b001000, "R3 taskfile read");
    acc(1, 12'h070, 0, 32'hC4, 0, 0, 6'b000100, "R3 taskfile write");
    acc(0, 12'h010, 1, 0, 1, 32'hFFFFFFFF, 6'b000000, "R3 wrong size read");
    acc(1, 12'h020, 2, 32'h1, 0, 0, 6'b000000, "R3 wrong size write");
    // R4
    acc(0, 12'h080, 0, 0, 1, 32'h5A, 6'b000010, "R4 alt status idx8");
    acc(0, 12'h160, 0, 0, 1, 32'h5A, 6'b000010, "R4 alt status idx16");
    acc(1, 12'h160, 0, 32'h02, 0, 0, 6'b000001, "R4 control write");
    acc(0, 12'h080, 2, 0, 1, 32'hFFFFFFFF, 6'b000000, "R4 wrong size read");
    // R1
    acc(0, 12'h0A0, 0, 0, 1, 32'hFFFFFFFF, 6'b000000, "R1 undecoded idx A");
    acc(0, 12'hFF0, 2, 0, 1, 32'hFFFFFFFF, 6'b000000, "R1 undecoded idx FF");
    acc(1, 12'h400, 2, 32'h5, 0, 0, 6'b000000, "R1 undecoded write");
    // R6 / R7
    set_irq(1, 0);
    acc(0, 12'h300, 2, 0, 1, 32'h80000000, 6'b000000, "R7 dma rise sets bit31");
    acc(0, 12'h300, 0, 0, 1, 32'hFFFFFFFF, 6'b000000, "R6 byte read refused");
    acc(1, 12'h300, 2, 32'h7FFFFFFF, 0, 0, 6'b000000, "R7 write without bit31");
    acc(0, 12'h300, 2, 0, 1, 32'h80000000, 6'b000000, "R7 bit31 kept");
    acc(1, 12'h300, 2, 32'h80000000, 0, 0, 6'b000000, "R7 w1c");
    acc(0, 12'h300, 2, 0, 1, 32'h0, 6'b000000, "R7 cleared by write");
    set_irq(0, 0);
    set_irq(1, 0);
    acc(0, 12'h300, 2, 0, 1, 32'h80000000, 6'b000000, "R7 re-rise sets");
    set_irq(0, 0);
    acc(0, 12'h300, 2, 0, 1, 32'h0, 6'b000000, "R7 fall clears");
    // R7 same-cycle race: rise and w1c together, rise wins
    begin
      exp_t e;
      @(negedge clk);
      dma_irq_in = 1;
      bus_valid = 1; bus_write = 1; bus_addr = 12'h300; bus_size = 2; bus_wdata = 32'h80000000;
      e.chk_rd = 0; e.rdata = 0; e.strb = 0; e.wide = 1; e.sel = 0; e.tag = "R7 race write";
      q.push_back(e);
      @(posedge clk); #1; bus_valid = 0;
    end
    acc(0, 12'h300, 2, 0, 1, 32'h80000000, 6'b000000, "R7 race edge wins");
    // R8
    set_irq(0, 1);
    acc(0, 12'h300, 2, 0, 1, 32'h40000000, 6'b000000, "R8 disk mirror set");
    acc(1, 12'h300, 2, 32'hFFFFFFFF, 0, 0, 6'b000000, "R8 write all ones");
    acc(0, 12'h300, 2, 0, 1, 32'h40000000, 6'b000000, "R8 disk bit kept");
    set_irq(0, 0);
    acc(0, 12'h300, 2, 0, 1, 32'h0, 6'b000000, "R8 disk mirror clear");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule